// File: doc/BRIEF.md
# Gradual Voltage-Frequency Step Sequencer

This block walks one clock domain's supply setting and clock setting toward a requested operating point, a single point at a time, while the domain keeps running. Operating points are numbered from 0 (lowest voltage, lowest frequency) up to `NUM_POINTS-1`. The voltage index and the frequency index are kept as two separate registered outputs. The regulator and the clock generator follow these outputs.

The ordering keeps the supply sufficient for the clock at all times. On the way up, the voltage index is raised first, and the frequency index follows one settle interval later. On the way down, the frequency index drops first, and the voltage index follows one settle interval later. After every index change, the block waits a fixed settle interval before the next change. That interval is a cycle count parameter; 43 cycles is about 0.17 µs at 250 MHz.

A new target can arrive at any time. It is latched at once, but it only acts at the next step boundary, and a half-finished step is always completed first. The busy output tells the controller that feeds the targets when the domain has settled.

Top module: `vf_step_seq`

## Requirements
- R1: In reset and on the first cycle after it, both indices and the latched target equal `RESET_IDX` (default 0), and busy is low.
- R2: The voltage index is never below the frequency index.
- R3: The two indices never differ by more than one. A move up changes the voltage index first and never lowers either index. A move down changes the frequency index first and never raises either index.
- R4: Any index change is exactly +1 or -1, and the two indices never change on the same cycle.
- R5: From a settled state, the first index change lands on the clock edge after the one that latches the target. Successive index changes are exactly `SETTLE_CYCLES` cycles apart.
- R6: A target is latched on any edge where `tgt_valid` is high. A value above `NUM_POINTS-1` is clamped to `NUM_POINTS-1`, and both indices finish equal to the latched target.
- R7: Busy is high while either index differs from the latched target, or while a settle interval is running. For a move of d points from a settled state, busy is high for exactly 2·d·`SETTLE_CYCLES`+1 cycles, starting with the cycle after the latching edge.
- R8: A target that arrives while the indices differ is not applied until the pending half-step finishes. If the new target reverses direction, the lagging index first catches up to the leading one.
- R9: Requesting the current operating point while settled has no effect: the indices stay put and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_idx | input | IDX_W | Requested operating point |
| tgt_valid | input | 1 | Latch `tgt_idx` on this edge |
| volt_idx | output | IDX_W | Current supply operating-point index |
| freq_idx | output | IDX_W | Current clock operating-point index |
| busy | output | 1 | Sequence or settle interval in progress |

## Verification
Two events can fall on the same cycle: a new target being latched, and the settle timer expiring on a step boundary while one index leads the other. The bench provokes this by sending a reversing target immediately after an upward voltage step. It then checks that the frequency index still catches up to that voltage value before anything descends. It also checks that no cycle changes both indices. Every start and end pair in a small configuration is swept as well, and the busy duration and the spacing between changes are compared with the arithmetic 2·d·S+1 and S.

// File: rtl/vf_seq_pkg.sv
package vf_seq_pkg;

  typedef enum logic [2:0] {
    STEP_NONE  = 3'd0,
    STEP_V_UP  = 3'd1,
    STEP_F_UP  = 3'd2,
    STEP_F_DN  = 3'd3,
    STEP_V_DN  = 3'd4
  } step_e;

endpackage

// File: rtl/vf_target_latch.sv
module vf_target_latch #(
  parameter int NUM_POINTS = 320,
  parameter int IDX_W      = $clog2(NUM_POINTS),
  parameter int RESET_IDX  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             req_valid,
  output logic [IDX_W-1:0] goal_q
);

  localparam logic [IDX_W-1:0] MAX_IDX  = IDX_W'(NUM_POINTS - 1);
  localparam logic [IDX_W-1:0] INIT_IDX = IDX_W'(RESET_IDX);

  logic [IDX_W-1:0] clamped;

  always_comb begin
    clamped = (req_idx > MAX_IDX) ? MAX_IDX : req_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) goal_q <= INIT_IDX;
    else if (req_valid) goal_q <= clamped;
  end

  // R6: the latched target never exceeds the top operating point
  a_r6_goal_in_range: assert property (@(posedge clk) disable iff (rst)
    goal_q <= MAX_IDX);

endmodule

// File: rtl/vf_settle_timer.sv
module vf_settle_timer #(
  parameter int SETTLE_CYCLES = 43,
  parameter int CNT_W         = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ready,
  output logic counting
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYCLES - 1);

  logic             wait_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    ready    = !wait_q || (cnt_q == '0);
    counting = wait_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      wait_q <= 1'b1;
      cnt_q  <= LOAD_VAL;
    end else if (wait_q) begin
      if (cnt_q == '0) wait_q <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5: a step may only be launched when the timer reports ready
  a_r5_start_when_ready: assert property (@(posedge clk) disable iff (rst)
    start |-> ready);

  // R5: a fresh interval blocks the next step on the following cycle
  a_r5_start_blocks: assert property (@(posedge clk) disable iff (rst)
    start |=> (counting && !ready));

endmodule

// File: rtl/vf_step_decide.sv
module vf_step_decide
  import vf_seq_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic [IDX_W-1:0] v_cur,
  input  logic [IDX_W-1:0] f_cur,
  input  logic [IDX_W-1:0] goal,
  input  logic             going_up,
  input  logic             slot_open,
  output step_e            step
);

  always_comb begin
    step = STEP_NONE;
    if (slot_open) begin
      if (v_cur != f_cur) begin
        // finish the half-step already started, whatever the goal says
        step = going_up ? STEP_F_UP : STEP_V_DN;
      end else if (goal > v_cur) begin
        step = STEP_V_UP;
      end else if (goal < v_cur) begin
        step = STEP_F_DN;
      end
    end
  end

endmodule

// File: rtl/vf_index_regs.sv
module vf_index_regs
  import vf_seq_pkg::*;
#(
  parameter int IDX_W     = 9,
  parameter int RESET_IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  step_e            step,
  output logic [IDX_W-1:0] v_q,
  output logic [IDX_W-1:0] f_q,
  output logic             up_q
);

  localparam logic [IDX_W-1:0] INIT_IDX = IDX_W'(RESET_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q  <= INIT_IDX;
      f_q  <= INIT_IDX;
      up_q <= 1'b1;
    end else begin
      unique case (step)
        STEP_V_UP: begin
          v_q  <= v_q + 1'b1;
          up_q <= 1'b1;
        end
        STEP_F_UP: f_q <= f_q + 1'b1;
        STEP_F_DN: begin
          f_q  <= f_q - 1'b1;
          up_q <= 1'b0;
        end
        STEP_V_DN: v_q <= v_q - 1'b1;
        default: ;
      endcase
    end
  end

  // R2: supply index never below clock index
  a_r2_volt_not_below_freq: assert property (@(posedge clk) disable iff (rst)
    v_q >= f_q);

  // R3: indices never drift apart by more than one point
  a_r3_gap_at_most_one: assert property (@(posedge clk) disable iff (rst)
    (v_q - f_q) <= IDX_W'(1));

  // R4: each register moves by at most one point per cycle
  a_r4_volt_unit_step: assert property (@(posedge clk) disable iff (rst)
    (v_q == $past(v_q)) || (v_q == $past(v_q) + IDX_W'(1)) || (v_q == $past(v_q) - IDX_W'(1)));
  a_r4_freq_unit_step: assert property (@(posedge clk) disable iff (rst)
    (f_q == $past(f_q)) || (f_q == $past(f_q) + IDX_W'(1)) || (f_q == $past(f_q) - IDX_W'(1)));

endmodule

// File: rtl/vf_step_seq.sv
module vf_step_seq
  import vf_seq_pkg::*;
#(
  parameter int NUM_POINTS    = 320,
  parameter int SETTLE_CYCLES = 43,
  parameter int RESET_IDX     = 0,
  parameter int IDX_W         = $clog2(NUM_POINTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] tgt_idx,
  input  logic             tgt_valid,
  output logic [IDX_W-1:0] volt_idx,
  output logic [IDX_W-1:0] freq_idx,
  output logic             busy
);

  localparam int SINCE_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SINCE_W-1:0] SINCE_SAT = SINCE_W'(SETTLE_CYCLES);
  localparam logic [IDX_W-1:0]   INIT_IDX  = IDX_W'(RESET_IDX);

  logic [IDX_W-1:0] goal_q;
  logic [IDX_W-1:0] v_q, f_q;
  logic             up_q;
  logic             slot_open, settling;
  step_e            step;

  vf_target_latch #(
    .NUM_POINTS(NUM_POINTS), .IDX_W(IDX_W), .RESET_IDX(RESET_IDX)
  ) u_goal (
    .clk(clk), .rst(rst), .req_idx(tgt_idx), .req_valid(tgt_valid), .goal_q(goal_q)
  );

  vf_settle_timer #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_timer (
    .clk(clk), .rst(rst), .start(step != STEP_NONE), .ready(slot_open), .counting(settling)
  );

  vf_step_decide #(
    .IDX_W(IDX_W)
  ) u_decide (
    .v_cur(v_q), .f_cur(f_q), .goal(goal_q), .going_up(up_q),
    .slot_open(slot_open), .step(step)
  );

  vf_index_regs #(
    .IDX_W(IDX_W), .RESET_IDX(RESET_IDX)
  ) u_regs (
    .clk(clk), .rst(rst), .step(step), .v_q(v_q), .f_q(f_q), .up_q(up_q)
  );

  always_comb begin
    volt_idx = v_q;
    freq_idx = f_q;
    busy     = settling || (v_q != goal_q) || (f_q != goal_q);
  end

  // Spacing checker: cycles since an index change was last seen at the outputs
  logic [IDX_W-1:0]   v_prev, f_prev;
  logic [SINCE_W-1:0] since_q;
  logic               moved;

  always_comb moved = (v_q != v_prev) || (f_q != f_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_prev  <= INIT_IDX;
      f_prev  <= INIT_IDX;
      since_q <= SINCE_SAT;
    end else begin
      v_prev <= v_q;
      f_prev <= f_q;
      if (moved) since_q <= SINCE_W'(1);
      else if (since_q != SINCE_SAT) since_q <= since_q + 1'b1;
    end
  end

  // R5: successive index changes are a full settle interval apart
  a_r5_step_spacing: assert property (@(posedge clk) disable iff (rst)
    moved |-> (since_q >= SINCE_SAT));

  // R4: the two indices never change on the same cycle
  a_r4_one_index_per_cycle: assert property (@(posedge clk) disable iff (rst)
    !((v_q != v_prev) && (f_q != f_prev)));

  // R7: any mismatch against the latched target shows as busy
  a_r7_busy_on_mismatch: assert property (@(posedge clk) disable iff (rst)
    ((v_q != goal_q) || (f_q != goal_q)) |-> busy);

  // R1: state just after reset is the reset operating point, idle
  a_r1_reset_state: assert property (@(posedge clk)
    $fell(rst) |-> (v_q == INIT_IDX && f_q == INIT_IDX && !busy));

endmodule

// File: tb/vf_step_seq_tb_top.sv
`timescale 1ns/1ps
module vf_step_seq_tb_top;

  localparam int NP    = 12;
  localparam int S     = 4;
  localparam int IW    = $clog2(NP);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [IW-1:0] tgt_idx = '0;
  logic          tgt_valid = 1'b0;
  logic [IW-1:0] volt_idx, freq_idx;
  logic          busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  vf_step_seq #(.NUM_POINTS(NP), .SETTLE_CYCLES(S), .RESET_IDX(0)) dut_i (
    .clk(clk), .rst(rst), .tgt_idx(tgt_idx), .tgt_valid(tgt_valid),
    .volt_idx(volt_idx), .freq_idx(freq_idx), .busy(busy)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse a target at a negedge; returns after the negedge that follows the latching edge
  task automatic pulse_target(input int t);
    tgt_idx   = IW'(t);
    tgt_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tgt_valid = 1'b0;
  endtask

  // Move from a settled state and check timing, ordering and end point
  task automatic do_move(input int t);
    int start = int'(volt_idx);
    int goal  = (t > NP - 1) ? NP - 1 : t;
    int d     = (goal > start) ? goal - start : start - goal;
    bit up    = goal > start;
    int pv = start, pf = start;
    int n = 0, last_chg = -1;
    int bad2 = 0, bad3 = 0, bad4 = 0, bad5 = 0;
    pulse_target(t);
    while (busy && n < 2000) begin
      int v = int'(volt_idx), f = int'(freq_idx);
      if (v < f) bad2++;
      if (v - f > 1) bad3++;
      if (up && (v < pv || f < pf)) bad3++;
      if (!up && (v > pv || f > pf)) bad3++;
      if (v != pv && f != pf) bad4++;
      if (v - pv > 1 || pv - v > 1 || f - pf > 1 || pf - f > 1) bad4++;
      if (v != pv || f != pf) begin
        if (last_chg < 0) begin if (n != 1) bad5++; end
        else if (n - last_chg != S) bad5++;
        last_chg = n;
      end
      pv = v; pf = f;
      n++;
      @(negedge clk);
    end
    chk(bad2 == 0, "R2 volt below freq", bad2, 0);
    chk(bad3 == 0, "R3 gap/ordering", bad3, 0);
    chk(bad4 == 0, "R4 unit single-index step", bad4, 0);
    chk(bad5 == 0, "R5 step spacing", bad5, 0);
    chk(n == ((d > 0) ? 2 * d * S + 1 : 0), "R7 busy duration", n, (d > 0) ? 2 * d * S + 1 : 0);
    chk(int'(volt_idx) == goal, "R6 final volt", int'(volt_idx), goal);
    chk(int'(freq_idx) == goal, "R6 final freq", int'(freq_idx), goal);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(volt_idx == '0, "R1 volt after reset", int'(volt_idx), 0);
    chk(freq_idx == '0, "R1 freq after reset", int'(freq_idx), 0);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

    // R9: request current point while settled
    do_move(0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && volt_idx == '0 && freq_idx == '0, "R9 same target no effect",
        int'(busy), 0);

    // Sweep every start/end pair
    for (int a = 0; a < NP; a++) begin
      for (int b = 0; b < NP; b++) begin
        do_move(a);
        do_move(b);
      end
    end

    // R6 clamp: beyond the top point
    do_move(3);
    do_move(15);
    chk(int'(volt_idx) == NP - 1, "R6 clamp", int'(volt_idx), NP - 1);
    do_move(NP - 1);
    chk(busy == 1'b0, "R9 same target at top", int'(busy), 0);

    // R8: reversal right after a voltage-led step
    do_move(2);
    begin
      int v0, maxf = 0, n = 0, bad = 0;
      pulse_target(9);
      while (volt_idx == freq_idx && n < 100) begin n++; @(negedge clk); end
      v0 = int'(volt_idx);
      chk(v0 == 3, "R8 first up step taken", v0, 3);
      pulse_target(0);
      n = 0;
      while (busy && n < 2000) begin
        if (int'(freq_idx) > maxf) maxf = int'(freq_idx);
        if (volt_idx < freq_idx) bad++;
        n++;
        @(negedge clk);
      end
      chk(maxf == v0, "R8 pending freq step completed", maxf, v0);
      chk(bad == 0, "R8/R2 ordering on reversal", bad, 0);
      chk(volt_idx == '0 && freq_idx == '0, "R8 reached new target", int'(volt_idx), 0);
    end

    finish_run();
  end

endmodule